// File: doc/BRIEF.md
# Performance Event Context Filter

This block decides, for each of a set of performance counters, whether one translation event should be counted. Every counter has its own selector: an event code, an inhibit bit, a bit that picks which identifier pair is compared, enables for a process-level filter and a device-level filter, a range-mask enable, a 24-bit device/guest-context identifier and a 20-bit process/address-space identifier. The event arrives with its code and its transaction context: a device ID, a process ID with a valid flag, a guest context ID and an address-space ID.

The context is captured when the event strobe is high. One cycle later the block registers a vector with one hit bit per counter and a valid pulse. The counters themselves sit outside the block. When the range mask is enabled, the programmed device/guest identifier carries both a base and a block size. Its trailing ones, together with the lowest clear bit above them, are left out of the comparison. This selects a power-of-two-aligned block of identifiers.

Top module: `evf_filter_top`

## Requirements
- R1: While reset is high and in the cycle after it, `hit_valid` is 0 and `hit` is all zeros.
- R2: An event strobed before clock edge k gives `hit_valid`=1 after edge k+1, for exactly one cycle. `hit` is all zeros whenever `hit_valid` is 0.
- R3: A counter hits only when its event code equals the event's code and that code is not 0. Code 0 means "no event" and never hits.
- R4: A counter whose inhibit bit is 1 never hits.
- R5: When the identifier-type bit is 1, the device filter uses the guest context ID and the process filter uses the address-space ID. When the bit is 0, they use the device ID and the process ID.
- R6: With the process filter enabled and the process-valid flag at 1, the counter hits only if its 20-bit process field equals the selected process-side ID.
- R7: With the process filter enabled and the process-valid flag at 0, the process comparison passes whatever the IDs are.
- R8: With the device filter enabled and the range mask off, all 24 bits of the programmed device field must equal the selected device-side ID.
- R9: With the range mask on, the compared bits are ~(id ^ (id+1)) for the programmed id. Only the bits above its lowest clear bit are compared, so an all-ones id matches any ID.
- R10: With the device filter disabled, the device comparison always passes.
- R11: Each counter's hit bit depends only on that counter's own selector fields. Counter i drives `hit[i]`, and its code sits in `cfg_code[8*i +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event strobe; the context is captured on this edge |
| evt_code | input | 8 | Event code of the translation event |
| ctx_dev_id | input | 24 | Device ID of the transaction |
| ctx_proc_id | input | 20 | Process ID of the transaction |
| ctx_proc_vld | input | 1 | Process ID is valid |
| ctx_gctx_id | input | 24 | Guest context ID |
| ctx_as_id | input | 20 | Address-space ID |
| cfg_code | input | 8*NCTR | Per-counter event code |
| cfg_inhibit | input | NCTR | Per-counter inhibit |
| cfg_idtype | input | NCTR | Per-counter identifier-type select |
| cfg_pfilt | input | NCTR | Per-counter process filter enable |
| cfg_dfilt | input | NCTR | Per-counter device filter enable |
| cfg_dmask | input | NCTR | Per-counter range-mask enable |
| cfg_dev_sel | input | 24*NCTR | Per-counter device/guest identifier |
| cfg_proc_sel | input | 20*NCTR | Per-counter process/address-space identifier |
| hit_valid | output | 1 | Result valid pulse |
| hit | output | NCTR | Per-counter hit bits |

## Verification
The bench checks the range mask at its edges. An identifier ending in 0111 must accept IDs differing in bits 3..0 and reject one differing in bit 4; a mask built from the lowest set bit instead would get this wrong. An all-ones identifier must match the ID 0, where a mask that failed to wrap would reject it. A transaction without a valid process ID must pass the process filter, and a design that compares regardless would miss those events. Swapping the identifier-type selection would make guest-context vectors match on the device ID, and the bench checks for exactly that.

// File: rtl/evf_pkg.sv
package evf_pkg;
  localparam int CODE_W = 8;
  localparam int DEV_W  = 24;
  localparam int PROC_W = 20;

  typedef struct packed {
    logic [DEV_W-1:0]  dev;
    logic [PROC_W-1:0] proc;
    logic              pvld;
    logic [DEV_W-1:0]  gctx;
    logic [PROC_W-1:0] asid;
  } ctx_t;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              inhibit;
    logic              idtype;
    logic              pfilt;
    logic              dfilt;
    logic              dmask;
    logic [DEV_W-1:0]  dev_sel;
    logic [PROC_W-1:0] proc_sel;
  } sel_t;
endpackage

// File: rtl/evf_range_mask.sv
module evf_range_mask #(
  parameter int W = 24
) (
  input  logic [W-1:0] id_i,
  input  logic         en_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] low_run;

  always_comb begin
    low_run = id_i ^ (id_i + W'(1));
    mask_o  = en_i ? ~low_run : {W{1'b1}};
  end

  // R9: the ignored bits always form one run starting at bit 0
  always_comb begin
    assert_mask_shape_R9: assert ((~mask_o & (~mask_o + W'(1))) == '0);
  end
endmodule

// File: rtl/evf_counter_match.sv
module evf_counter_match
  import evf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  sel_t              sel_i,
  input  ctx_t              ctx_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              match_o
);
  logic [DEV_W-1:0]  dev_cmp;
  logic [PROC_W-1:0] proc_cmp;
  logic [DEV_W-1:0]  dev_mask;
  logic              code_ok, proc_ok, dev_ok;

  evf_range_mask #(.W(DEV_W)) u_mask (
    .id_i  (sel_i.dev_sel),
    .en_i  (sel_i.dmask),
    .mask_o(dev_mask)
  );

  always_comb begin
    dev_cmp  = sel_i.idtype ? ctx_i.gctx : ctx_i.dev;
    proc_cmp = sel_i.idtype ? ctx_i.asid : ctx_i.proc;
    code_ok  = (code_i != '0) && (code_i == sel_i.code);
    proc_ok  = !sel_i.pfilt || !ctx_i.pvld || (sel_i.proc_sel == proc_cmp);
    dev_ok   = !sel_i.dfilt || (((sel_i.dev_sel ^ dev_cmp) & dev_mask) == '0);
    match_o  = code_ok && !sel_i.inhibit && proc_ok && dev_ok;
  end

  assert_inhibit_R4: assert property (@(posedge clk) disable iff (rst)
    sel_i.inhibit |-> !match_o);
  assert_code_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (code_i == '0) |-> !match_o);
  // R7 and R10: unfiltered device side, no valid process ID, code equal -> hit
  assert_open_filters_R7: assert property (@(posedge clk) disable iff (rst)
    (!sel_i.dfilt && !ctx_i.pvld && !sel_i.inhibit && code_i != '0
     && code_i == sel_i.code) |-> match_o);
endmodule

// File: rtl/evf_filter_top.sv
module evf_filter_top
  import evf_pkg::*;
#(
  parameter int NCTR = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     evt_valid,
  input  logic [CODE_W-1:0]        evt_code,
  input  logic [DEV_W-1:0]         ctx_dev_id,
  input  logic [PROC_W-1:0]        ctx_proc_id,
  input  logic                     ctx_proc_vld,
  input  logic [DEV_W-1:0]         ctx_gctx_id,
  input  logic [PROC_W-1:0]        ctx_as_id,
  input  logic [NCTR*CODE_W-1:0]   cfg_code,
  input  logic [NCTR-1:0]          cfg_inhibit,
  input  logic [NCTR-1:0]          cfg_idtype,
  input  logic [NCTR-1:0]          cfg_pfilt,
  input  logic [NCTR-1:0]          cfg_dfilt,
  input  logic [NCTR-1:0]          cfg_dmask,
  input  logic [NCTR*DEV_W-1:0]    cfg_dev_sel,
  input  logic [NCTR*PROC_W-1:0]   cfg_proc_sel,
  output logic                     hit_valid,
  output logic [NCTR-1:0]          hit
);
  ctx_t              ctx_q;
  logic [CODE_W-1:0] code_q;
  logic              vld_q;
  logic [NCTR-1:0]   match_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      code_q <= '0;
      ctx_q  <= '0;
    end else begin
      vld_q <= evt_valid;
      if (evt_valid) begin
        code_q     <= evt_code;
        ctx_q.dev  <= ctx_dev_id;
        ctx_q.proc <= ctx_proc_id;
        ctx_q.pvld <= ctx_proc_vld;
        ctx_q.gctx <= ctx_gctx_id;
        ctx_q.asid <= ctx_as_id;
      end
    end
  end

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    sel_t sel;
    always_comb begin
      sel.code     = cfg_code[i*CODE_W +: CODE_W];
      sel.inhibit  = cfg_inhibit[i];
      sel.idtype   = cfg_idtype[i];
      sel.pfilt    = cfg_pfilt[i];
      sel.dfilt    = cfg_dfilt[i];
      sel.dmask    = cfg_dmask[i];
      sel.dev_sel  = cfg_dev_sel[i*DEV_W +: DEV_W];
      sel.proc_sel = cfg_proc_sel[i*PROC_W +: PROC_W];
    end
    evf_counter_match u_match (
      .clk    (clk),
      .rst    (rst),
      .sel_i  (sel),
      .ctx_i  (ctx_q),
      .code_i (code_q),
      .match_o(match_w[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit       <= '0;
    end else begin
      hit_valid <= vld_q;
      hit       <= vld_q ? match_w : '0;
    end
  end

  assert_hit_gated_R2: assert property (@(posedge clk) disable iff (rst)
    !hit_valid |-> (hit == '0));
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> $past(evt_valid, 2));
endmodule

// File: tb/sim_evf_filter_top.sv
module sim_evf_filter_top;
  localparam int NCTR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_valid = 1'b0;
  logic [7:0] evt_code = '0;
  logic [23:0] ctx_dev_id = '0, ctx_gctx_id = '0;
  logic [19:0] ctx_proc_id = '0, ctx_as_id = '0;
  logic ctx_proc_vld = 1'b0;
  logic [NCTR*8-1:0]  cfg_code = '0;
  logic [NCTR-1:0]    cfg_inhibit = '1, cfg_idtype = '0, cfg_pfilt = '0,
                      cfg_dfilt = '0, cfg_dmask = '0;
  logic [NCTR*24-1:0] cfg_dev_sel = '0;
  logic [NCTR*20-1:0] cfg_proc_sel = '0;
  logic hit_valid;
  logic [NCTR-1:0] hit;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  evf_filter_top #(.NCTR(NCTR)) u0 (.*);

  typedef struct packed {
    logic [7:0]  code_cfg;
    logic        inh, idt, pf, df, dm;
    logic [23:0] did;
    logic [19:0] pid;
    logic [7:0]  code_ev;
    logic [23:0] dev;
    logic [19:0] proc;
    logic        pv;
    logic [23:0] gs;
    logic [19:0] as;
    logic        exp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{8'h05,1'b0,1'b0,1'b0,1'b0,1'b0,24'h0,20'h0,8'h05,24'h0,20'h0,1'b0,24'h0,20'h0,1'b1}, // R3 equal
    '{8'h05,1'b0,1'b0,1'b0,1'b0,1'b0,24'h0,20'h0,8'h06,24'h0,20'h0,1'b0,24'h0,20'h0,1'b0}, // R3 differ
    '{8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,24'h0,20'h0,8'h00,24'h0,20'h0,1'b0,24'h0,20'h0,1'b0}, // R3 code 0
    '{8'h05,1'b1,1'b0,1'b0,1'b0,1'b0,24'h0,20'h0,8'h05,24'h0,20'h0,1'b0,24'h0,20'h0,1'b0}, // R4
    '{8'h07,1'b0,1'b0,1'b0,1'b1,1'b0,24'h123456,20'h0,8'h07,24'h123456,20'h0,1'b0,24'h0,20'h0,1'b1}, // R8 eq
    '{8'h07,1'b0,1'b0,1'b0,1'b1,1'b0,24'h123456,20'h0,8'h07,24'h123457,20'h0,1'b0,24'h0,20'h0,1'b0}, // R8 ne
    '{8'h07,1'b0,1'b0,1'b0,1'b1,1'b1,24'h123457,20'h0,8'h07,24'h123450,20'h0,1'b0,24'h0,20'h0,1'b1}, // R9
    '{8'h07,1'b0,1'b0,1'b0,1'b1,1'b1,24'h123457,20'h0,8'h07,24'h12345F,20'h0,1'b0,24'h0,20'h0,1'b1}, // R9
    '{8'h07,1'b0,1'b0,1'b0,1'b1,1'b1,24'h123457,20'h0,8'h07,24'h123467,20'h0,1'b0,24'h0,20'h0,1'b0}, // R9 bit4
    '{8'h07,1'b0,1'b0,1'b0,1'b1,1'b1,24'hFFFFFF,20'h0,8'h07,24'h000000,20'h0,1'b0,24'h0,20'h0,1'b1}, // R9 all ones
    '{8'h07,1'b0,1'b0,1'b0,1'b1,1'b1,24'h123456,20'h0,8'h07,24'h123457,20'h0,1'b0,24'h0,20'h0,1'b1}, // R9 bit0
    '{8'h07,1'b0,1'b0,1'b0,1'b1,1'b1,24'h123456,20'h0,8'h07,24'h123446,20'h0,1'b0,24'h0,20'h0,1'b0}, // R9 high bit
    '{8'h07,1'b0,1'b0,1'b0,1'b0,1'b0,24'hABCDEF,20'h0,8'h07,24'h000000,20'h0,1'b0,24'h0,20'h0,1'b1}, // R10
    '{8'h09,1'b0,1'b0,1'b1,1'b0,1'b0,24'h0,20'h12345,8'h09,24'h0,20'h12345,1'b1,24'h0,20'h0,1'b1}, // R6 eq
    '{8'h09,1'b0,1'b0,1'b1,1'b0,1'b0,24'h0,20'h12345,8'h09,24'h0,20'h12346,1'b1,24'h0,20'h0,1'b0}, // R6 ne
    '{8'h09,1'b0,1'b0,1'b1,1'b0,1'b0,24'h0,20'h12345,8'h09,24'h0,20'h00000,1'b0,24'h0,20'h0,1'b1}, // R7
    '{8'h09,1'b0,1'b0,1'b1,1'b0,1'b0,24'h0,20'h12345,8'h09,24'h0,20'hFFFFF,1'b0,24'h0,20'h0,1'b1}, // R7
    '{8'h0A,1'b0,1'b1,1'b0,1'b1,1'b0,24'h00AA00,20'h0,8'h0A,24'h00AA00,20'h0,1'b0,24'h00BB00,20'h0,1'b0}, // R5
    '{8'h0A,1'b0,1'b1,1'b0,1'b1,1'b0,24'h00AA00,20'h0,8'h0A,24'h000000,20'h0,1'b0,24'h00AA00,20'h0,1'b1}, // R5
    '{8'h0A,1'b0,1'b1,1'b1,1'b0,1'b0,24'h0,20'h00011,8'h0A,24'h0,20'h00022,1'b1,24'h0,20'h00011,1'b1}, // R5
    '{8'h0A,1'b0,1'b0,1'b1,1'b0,1'b0,24'h0,20'h00011,8'h0A,24'h0,20'h00022,1'b1,24'h0,20'h00011,1'b0}  // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctr(input int i, input vec_t v);
    cfg_code[i*8 +: 8]      = v.code_cfg;
    cfg_inhibit[i]          = v.inh;
    cfg_idtype[i]           = v.idt;
    cfg_pfilt[i]            = v.pf;
    cfg_dfilt[i]            = v.df;
    cfg_dmask[i]            = v.dm;
    cfg_dev_sel[i*24 +: 24] = v.did;
    cfg_proc_sel[i*20 +: 20]= v.pid;
  endtask

  task automatic fire(input vec_t v);
    evt_valid    = 1'b1;
    evt_code     = v.code_ev;
    ctx_dev_id   = v.dev;
    ctx_proc_id  = v.proc;
    ctx_proc_vld = v.pv;
    ctx_gctx_id  = v.gs;
    ctx_as_id    = v.as;
    @(negedge clk);
    evt_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hit_valid in reset", {31'b0, hit_valid}, 32'd0);
    chk("R1 hit in reset", {28'b0, hit}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 hit_valid after reset", {31'b0, hit_valid}, 32'd0);

    for (int n = 0; n < NV; n++) begin
      set_ctr(0, VEC[n]);
      fire(VEC[n]);
      chk($sformatf("R2 valid vec%0d", n), {31'b0, hit_valid}, 32'd1);
      chk($sformatf("vector %0d (R3-R10)", n), {31'b0, hit[0]}, {31'b0, VEC[n].exp});
      chk($sformatf("R11 idle ctrs vec%0d", n), {29'b0, hit[3:1]}, 32'd0);
    end

    // R2: pulse lasts one cycle; no strobe, no result
    @(negedge clk);
    chk("R2 single pulse", {31'b0, hit_valid}, 32'd0);
    chk("R2 hit zero when idle", {28'b0, hit}, 32'd0);

    // R11: independent counters
    set_ctr(0, VEC[1]);  // code 5, no hit for event 5? (cfg 5, event below is 7)
    set_ctr(1, VEC[5]);  // device 123456 exact, event dev 123450 -> no
    set_ctr(2, VEC[6]);  // masked 12345x -> hit
    set_ctr(3, VEC[12]); // device filter off -> hit
    fire(VEC[6]);
    chk("R11 hit vector", {28'b0, hit}, 32'b1100);

    // R4 on one counter only
    cfg_inhibit[3] = 1'b1;
    fire(VEC[6]);
    chk("R4 inhibit counter 3", {28'b0, hit}, 32'b0100);

    // R1: reset mid-flight clears the pending result
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset clears valid", {31'b0, hit_valid}, 32'd0);
    @(negedge clk);
    chk("R1 no stale pulse", {31'b0, hit_valid}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule